// File: doc/BRIEF.md
# Descending Stack Pointer with Return-Address Sequencing

This unit keeps a 16-bit stack pointer for a small processor core. Software sees the pointer as two byte registers, one for the low byte and one for the high byte, and may rewrite either byte through I/O write strobes. The core also uses the unit to push or pop single bytes, and to save or restore a return address on a call, an interrupt entry or a return. For each such operation the unit drives the data-memory address, the write strobe and the write byte, or the read strobe. It then hands back the byte or the reassembled return address that the memory returns.

The stack fills toward lower addresses. The return address takes two bytes when the program memory is small. It takes three bytes when a wide mode input is set, and a return pops the same number of bytes. When software writes the low byte of the pointer, the unit opens a short window that holds off interrupts. The window lets the high byte be written before an interrupt can use a pointer that is only half updated. A flag also reports whenever the pointer has been moved down to the base of the valid stack area or below it.

Top module: `stkptr_unit`

## Requirements
- R1: After a synchronous reset the pointer equals the SP_RESET parameter (default 0x3FFF), and both irq_block and busy are low.
- R2: A push request accepted while idle makes one write in the next cycle: mem_we is high, mem_addr equals the current pointer, and mem_wdata equals push_byte. The pointer then drops by exactly one.
- R3: A pop request accepted while idle makes one read at the pointer plus one, with mem_re high, and the pointer then rises by exactly one. rd_valid is high in the cycle after each read, and rd_data carries the returned byte.
- R4: A call request writes the return address as 2 bytes when wide_ra is 0, or as 3 bytes when wide_ra is 1. The writes go to consecutive descending addresses starting at the pointer, least significant byte first, one byte per cycle. The pointer falls by the byte count.
- R5: A return request reads the same byte count at ascending addresses starting at the pointer plus one, and the pointer rises by that count. The first byte read is the most significant one. One cycle after the last read, ret_valid is high and ret_addr holds the address, with bits 23:16 zero in 2-byte mode.
- R6: The pointer reads back as sp_hi (bits 15:8) and sp_lo (bits 7:0). An I/O write replaces the selected byte from the next cycle on, and leaves the other byte unchanged.
- R7: A low-byte write raises irq_block from the next cycle on. irq_block stays high until four retire strobes have been counted, and it drops in the cycle after the fourth.
- R8: Any later I/O write that is not a low-byte write (a high-byte write or io_wr_other) clears irq_block at once, on the next edge. A new low-byte write restarts the count at four.
- R9: sp_low is high exactly when the pointer is 0x2000 or lower.
- R10: While busy is high, new requests are ignored. When several requests arrive together while idle, the priority is call, then return, then push, then pop. At most one memory access happens per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_lo | input | 1 | I/O write strobe for the low pointer byte |
| io_wr_hi | input | 1 | I/O write strobe for the high pointer byte |
| io_wr_other | input | 1 | Strobe for any other I/O register write |
| io_wdata | input | 8 | I/O write data |
| retire | input | 1 | One pulse per retired instruction |
| req_push | input | 1 | Push one byte |
| req_pop | input | 1 | Pop one byte |
| req_call | input | 1 | Save a return address (call or interrupt entry) |
| req_ret | input | 1 | Restore a return address |
| wide_ra | input | 1 | 1 selects a 3-byte return address, 0 selects 2 bytes |
| push_byte | input | 8 | Byte to push |
| call_addr | input | 24 | Return address to save |
| mem_rdata | input | 8 | Read data from memory, one cycle after mem_re |
| sp_lo | output | 8 | Pointer low byte |
| sp_hi | output | 8 | Pointer high byte |
| sp_low | output | 1 | Pointer is at or below the stack base |
| irq_block | output | 1 | Interrupts held off |
| busy | output | 1 | A stack operation is in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| rd_valid | output | 1 | rd_data holds a popped byte |
| rd_data | output | 8 | Popped byte |
| ret_valid | output | 1 | ret_addr holds a restored return address |
| ret_addr | output | 24 | Restored return address |

## Verification
The hardest states to reach from the ports are a request that arrives while a multi-byte call is still writing, and several requests that arrive in the same idle cycle. Directed steps raise a push one cycle after a call has been accepted, and raise push and pop together. The bench then checks that only the winning operation moved the pointer. The interrupt window is exercised in three ways: it is allowed to run out on retire strobes, it is cut short by an unrelated I/O write, and it is restarted by a second low-byte write. A seeded random mix of pushes, pops, calls and returns in both address widths follows. It checks every address, byte and reassembled return address against a shadow memory kept in the bench.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    // Operation currently owned by the sequencer
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH,
        SQ_POP,
        SQ_CALL,
        SQ_RET
    } sq_kind_t;

    // Pointer movement requested by the sequencer
    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_DN,
        STEP_UP
    } sp_step_t;

    // Sequencer state: kind, beats left, return-address shifter, push byte
    typedef struct packed {
        sq_kind_t    kind;
        logic [1:0]  left;
        logic [23:0] rabuf;
        logic [7:0]  pdata;
    } sq_state_t;

    // Return-address length in bytes for the selected width mode
    function automatic logic [1:0] ra_len(input logic wide);
        return wide ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/stkptr_reg.sv
module stkptr_reg
    import stkptr_pkg::*;
#(
    parameter int              SP_W     = 16,
    parameter logic [SP_W-1:0] SP_RESET = 16'h3FFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [7:0]      wdata,
    input  sp_step_t        step,
    output logic [SP_W-1:0] sp
);
    localparam int              HI_W = SP_W - 8;
    localparam logic [SP_W-1:0] ONE  = {{(SP_W-1){1'b0}}, 1'b1};

    // A byte write from software takes precedence over a sequencer step
    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) sp[7:0]      <= wdata;
            if (wr_hi) sp[SP_W-1:8] <= wdata[HI_W-1:0];
        end else begin
            case (step)
                STEP_DN: sp <= sp - ONE;
                STEP_UP: sp <= sp + ONE;
                default: sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/stkptr_guard.sv
module stkptr_guard #(
    parameter int INHIBIT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_lo,
    input  logic wr_hi,
    input  logic wr_other,
    input  logic retire,
    output logic irq_block
);
    localparam int            CW    = $clog2(INHIBIT_LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(INHIBIT_LEN);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                              cnt <= '0;
        else if (wr_lo)                       cnt <= LEN_V;
        else if (wr_hi || wr_other)           cnt <= '0;
        else if (retire && (cnt != '0))       cnt <= cnt - ONE_V;
    end

    assign irq_block = (cnt != '0);
endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
    import stkptr_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_push,
    input  logic            req_pop,
    input  logic            req_call,
    input  logic            req_ret,
    input  logic            wide,
    input  logic [7:0]      push_byte,
    input  logic [23:0]     call_addr,
    input  logic [SP_W-1:0] sp,
    input  logic [7:0]      mem_rdata,
    output logic            busy,
    output sp_step_t        step,
    output logic            mem_we,
    output logic            mem_re,
    output logic [SP_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            ret_valid,
    output logic [23:0]     ret_addr
);
    localparam logic [SP_W-1:0] ONE = {{(SP_W-1){1'b0}}, 1'b1};

    sq_state_t st;
    logic      rd_pend, ret_pend, ret_last;
    logic      last_beat;

    assign last_beat = (st.kind == SQ_PUSH) || (st.kind == SQ_POP) || (st.left == 2'd1);

    // Access for the current beat: writes use the pointer, reads pre-increment
    always_comb begin
        step      = STEP_HOLD;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = st.pdata;
        case (st.kind)
            SQ_PUSH: begin
                mem_we = 1'b1;
                step   = STEP_DN;
            end
            SQ_CALL: begin
                mem_we    = 1'b1;
                mem_wdata = st.rabuf[7:0];
                step      = STEP_DN;
            end
            SQ_POP, SQ_RET: begin
                mem_re   = 1'b1;
                mem_addr = sp + ONE;
                step     = STEP_UP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.kind  <= SQ_IDLE;
            st.left  <= '0;
            st.rabuf <= '0;
            st.pdata <= '0;
            rd_pend  <= 1'b0;
            ret_pend <= 1'b0;
            ret_last <= 1'b0;
        end else begin
            rd_pend  <= mem_re;
            ret_pend <= (st.kind == SQ_RET);
            ret_last <= (st.kind == SQ_RET) && last_beat;
            // Bytes that are not the last one shift in below the earlier ones
            if (ret_pend && !ret_last)
                st.rabuf <= {st.rabuf[15:0], mem_rdata};
            case (st.kind)
                SQ_IDLE: begin
                    if (req_call) begin
                        st.kind  <= SQ_CALL;
                        st.left  <= ra_len(wide);
                        st.rabuf <= wide ? call_addr : {8'h00, call_addr[15:0]};
                    end else if (req_ret) begin
                        st.kind  <= SQ_RET;
                        st.left  <= ra_len(wide);
                        st.rabuf <= '0;
                    end else if (req_push) begin
                        st.kind  <= SQ_PUSH;
                        st.pdata <= push_byte;
                    end else if (req_pop) begin
                        st.kind  <= SQ_POP;
                    end
                end
                SQ_CALL: begin
                    st.rabuf <= {8'h00, st.rabuf[23:8]};
                    if (last_beat) st.kind <= SQ_IDLE;
                    else           st.left <= st.left - 2'd1;
                end
                SQ_RET: begin
                    if (last_beat) st.kind <= SQ_IDLE;
                    else           st.left <= st.left - 2'd1;
                end
                default: st.kind <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (st.kind != SQ_IDLE);
    assign rd_valid  = rd_pend;
    assign rd_data   = mem_rdata;
    assign ret_valid = ret_pend && ret_last;
    assign ret_addr  = {st.rabuf[15:0], mem_rdata};
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int          SP_W        = 16,
    parameter logic [15:0] SP_RESET    = 16'h3FFF,
    parameter logic [15:0] STACK_FLOOR = 16'h2000,
    parameter int          INHIBIT_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_wr_lo,
    input  logic        io_wr_hi,
    input  logic        io_wr_other,
    input  logic [7:0]  io_wdata,
    input  logic        retire,
    input  logic        req_push,
    input  logic        req_pop,
    input  logic        req_call,
    input  logic        req_ret,
    input  logic        wide_ra,
    input  logic [7:0]  push_byte,
    input  logic [23:0] call_addr,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  sp_lo,
    output logic [7:0]  sp_hi,
    output logic        sp_low,
    output logic        irq_block,
    output logic        busy,
    output logic        mem_we,
    output logic        mem_re,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        ret_valid,
    output logic [23:0] ret_addr
);
    logic [SP_W-1:0] sp;
    sp_step_t        step;

    stkptr_reg #(.SP_W(SP_W), .SP_RESET(SP_RESET)) reg_i (
        .clk(clk), .rst(rst), .wr_lo(io_wr_lo), .wr_hi(io_wr_hi),
        .wdata(io_wdata), .step(step), .sp(sp)
    );

    stkptr_seq #(.SP_W(SP_W)) seq_i (
        .clk(clk), .rst(rst), .req_push(req_push), .req_pop(req_pop),
        .req_call(req_call), .req_ret(req_ret), .wide(wide_ra),
        .push_byte(push_byte), .call_addr(call_addr), .sp(sp),
        .mem_rdata(mem_rdata), .busy(busy), .step(step),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    stkptr_guard #(.INHIBIT_LEN(INHIBIT_LEN)) guard_i (
        .clk(clk), .rst(rst), .wr_lo(io_wr_lo), .wr_hi(io_wr_hi),
        .wr_other(io_wr_other), .retire(retire), .irq_block(irq_block)
    );

    assign sp_lo  = sp[7:0];
    assign sp_hi  = sp[15:8];
    assign sp_low = (sp <= STACK_FLOOR);
endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk (
    input logic        clk,
    input logic        rst,
    input logic        io_wr_lo,
    input logic        io_wr_hi,
    input logic        io_wr_other,
    input logic        retire,
    input logic [7:0]  sp_lo,
    input logic [7:0]  sp_hi,
    input logic        irq_block,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic        rd_valid
);
    logic [15:0] spv;
    assign spv = {sp_hi, sp_lo};

    AST_WR_AT_PTR:   assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_addr == spv);                               // R2
    AST_PUSH_DOWN:   assert property (@(posedge clk) disable iff (rst) (mem_we && !io_wr_lo && !io_wr_hi) |=> spv == $past(spv) - 16'd1); // R2
    AST_RD_ABOVE:    assert property (@(posedge clk) disable iff (rst) mem_re |-> mem_addr == spv + 16'd1);                        // R3
    AST_POP_UP:      assert property (@(posedge clk) disable iff (rst) (mem_re && !io_wr_lo && !io_wr_hi) |=> spv == $past(spv) + 16'd1); // R3
    AST_RD_LATENCY:  assert property (@(posedge clk) disable iff (rst) mem_re |=> rd_valid);                                       // R3
    AST_INH_OPEN:    assert property (@(posedge clk) disable iff (rst) io_wr_lo |=> irq_block);                                    // R7
    AST_INH_HOLD:    assert property (@(posedge clk) disable iff (rst) (irq_block && !retire && !io_wr_hi && !io_wr_other) |=> irq_block); // R7
    AST_INH_CUT:     assert property (@(posedge clk) disable iff (rst) ((io_wr_hi || io_wr_other) && !io_wr_lo) |=> !irq_block);  // R8
    AST_ONE_ACCESS:  assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re));                                       // R10
    AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_we && !mem_re));                            // R10
endmodule

bind stkptr_unit stkptr_chk chk_i (
    .clk(clk), .rst(rst), .io_wr_lo(io_wr_lo), .io_wr_hi(io_wr_hi),
    .io_wr_other(io_wr_other), .retire(retire), .sp_lo(sp_lo), .sp_hi(sp_hi),
    .irq_block(irq_block), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .rd_valid(rd_valid)
);

// File: tb/stkptr_unit_tb_top.sv
module stkptr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr_lo = 0, io_wr_hi = 0, io_wr_other = 0;
    logic [7:0]  io_wdata = 0;
    logic        retire = 0;
    logic        req_push = 0, req_pop = 0, req_call = 0, req_ret = 0, wide_ra = 0;
    logic [7:0]  push_byte = 0;
    logic [23:0] call_addr = 0;
    logic [7:0]  mem_rdata;
    logic [7:0]  sp_lo, sp_hi, mem_wdata, rd_data;
    logic        sp_low, irq_block, busy, mem_we, mem_re, rd_valid, ret_valid;
    logic [15:0] mem_addr;
    logic [23:0] ret_addr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [7:0]  bmem    [1024];
    logic [7:0]  ref_mem [1024];
    logic [7:0]  rq = 0;
    logic [15:0] sp_m;

    always #4 clk = ~clk;

    stkptr_unit dut_i (
        .clk(clk), .rst(rst), .io_wr_lo(io_wr_lo), .io_wr_hi(io_wr_hi),
        .io_wr_other(io_wr_other), .io_wdata(io_wdata), .retire(retire),
        .req_push(req_push), .req_pop(req_pop), .req_call(req_call),
        .req_ret(req_ret), .wide_ra(wide_ra), .push_byte(push_byte),
        .call_addr(call_addr), .mem_rdata(mem_rdata), .sp_lo(sp_lo),
        .sp_hi(sp_hi), .sp_low(sp_low), .irq_block(irq_block), .busy(busy),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    // Synchronous byte memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) rq <= bmem[mem_addr[9:0]];
    end
    assign mem_rdata = rq;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_at(input logic [15:0] a);
        return ref_mem[a[9:0]];
    endfunction

    function automatic logic [23:0] ret_expect(input logic [15:0] sp0, input logic w);
        logic [7:0] b0, b1, b2;
        b0 = ref_at(sp0 + 16'd1);
        b1 = ref_at(sp0 + 16'd2);
        b2 = ref_at(sp0 + 16'd3);
        return w ? {b0, b1, b2} : {8'h00, b0, b1};
    endfunction

    task automatic io_write(input bit hi, input logic [7:0] d);
        @(negedge clk);
        io_wr_lo = !hi; io_wr_hi = hi; io_wdata = d;
        @(negedge clk);
        io_wr_lo = 0; io_wr_hi = 0;
        if (hi) sp_m[15:8] = d; else sp_m[7:0] = d;
        chk({sp_hi, sp_lo} == sp_m, "R6 byte write", {16'h0, sp_hi, sp_lo}, {16'h0, sp_m});
    endtask

    task automatic pulse_retire();
        @(negedge clk); retire = 1;
        @(negedge clk); retire = 0;
    endtask

    // kind: 0 push, 1 pop, 2 call, 3 ret
    task automatic run_op(input int kind, input logic [7:0] pb, input logic [23:0] ca, input logic w);
        int n, k;
        logic [7:0]  bexp;
        logic [23:0] rexp;
        logic [7:0]  pexp;
        n = (kind >= 2) ? (w ? 3 : 2) : 1;
        rexp = ret_expect(sp_m, w);
        pexp = ref_at(sp_m + 16'd1);
        @(negedge clk);
        req_push = (kind == 0); req_pop = (kind == 1);
        req_call = (kind == 2); req_ret = (kind == 3);
        push_byte = pb; call_addr = ca; wide_ra = w;
        @(negedge clk);
        req_push = 0; req_pop = 0; req_call = 0; req_ret = 0;
        k = 0;
        while (busy) begin
            if (kind == 0 || kind == 2) begin
                bexp = (kind == 0) ? pb : ca[8*k +: 8];
                chk(mem_we && mem_addr == sp_m - 16'(k), (kind == 0) ? "R2 write addr" : "R4 write addr",
                    {15'h0, mem_we, mem_addr}, {16'h1, sp_m - 16'(k)});
                chk(mem_wdata == bexp, (kind == 0) ? "R2 write data" : "R4 byte order",
                    {24'h0, mem_wdata}, {24'h0, bexp});
                ref_mem[10'(sp_m - 16'(k))] = bexp;
            end else begin
                chk(mem_re && mem_addr == sp_m + 16'd1 + 16'(k), (kind == 1) ? "R3 read addr" : "R5 read addr",
                    {15'h0, mem_re, mem_addr}, {16'h1, sp_m + 16'd1 + 16'(k)});
            end
            k++;
            @(negedge clk);
        end
        chk(k == n, (kind >= 2) ? "R4 R5 byte count" : "R2 R3 byte count", 32'(k), 32'(n));
        if (kind <= 1 || kind == 2) begin
            if (kind == 1) begin
                chk(rd_valid && rd_data == pexp, "R3 pop data", {23'h0, rd_valid, rd_data}, {24'h1, pexp});
                sp_m = sp_m + 16'd1;
            end else begin
                sp_m = sp_m - 16'(n);
            end
        end else begin
            chk(ret_valid && ret_addr == rexp, "R5 return address", {7'h0, ret_valid, ret_addr}, {8'h1, rexp});
            sp_m = sp_m + 16'(n);
        end
        chk({sp_hi, sp_lo} == sp_m, "R2 R3 R4 R5 pointer", {16'h0, sp_hi, sp_lo}, {16'h0, sp_m});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        logic [15:0] sp0;
        seed_set = $urandom(32'd9137);
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 8'h00;
            ref_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        sp_m = 16'h3FFF;
        // R1 reset state
        chk({sp_hi, sp_lo} == 16'h3FFF, "R1 reset pointer", {16'h0, sp_hi, sp_lo}, 32'h3FFF);
        chk(!irq_block && !busy, "R1 reset flags", {30'h0, irq_block, busy}, 32'h0);
        chk(!sp_low, "R9 above floor", {31'h0, sp_low}, 32'h0);

        // R2 R3 directed push then pop
        run_op(0, 8'hA5, 24'h0, 0);
        run_op(0, 8'h3C, 24'h0, 0);
        run_op(1, 8'h00, 24'h0, 0);
        run_op(1, 8'h00, 24'h0, 0);

        // R4 R5 both widths
        run_op(2, 8'h00, 24'hC1B2A3, 0);
        run_op(3, 8'h00, 24'h0, 0);
        run_op(2, 8'h00, 24'h7E6D5C, 1);
        run_op(3, 8'h00, 24'h0, 1);

        // R7 window runs out on the fourth retire
        io_write(0, sp_m[7:0]);
        chk(irq_block, "R7 window opens", {31'h0, irq_block}, 32'h1);
        for (int i = 0; i < 3; i++) pulse_retire();
        chk(irq_block, "R7 held after three retires", {31'h0, irq_block}, 32'h1);
        pulse_retire();
        chk(!irq_block, "R7 closes after fourth retire", {31'h0, irq_block}, 32'h0);

        // R8 cut short by an unrelated I/O write
        io_write(0, sp_m[7:0]);
        pulse_retire();
        @(negedge clk); io_wr_other = 1;
        @(negedge clk); io_wr_other = 0;
        chk(!irq_block, "R8 other write ends window", {31'h0, irq_block}, 32'h0);

        // R8 restart by a second low write
        io_write(0, sp_m[7:0]);
        pulse_retire(); pulse_retire();
        io_write(0, sp_m[7:0]);
        for (int i = 0; i < 3; i++) pulse_retire();
        chk(irq_block, "R8 restarted window still open", {31'h0, irq_block}, 32'h1);
        pulse_retire();
        chk(!irq_block, "R8 restarted window closes", {31'h0, irq_block}, 32'h0);

        // R8 high write after low write closes window
        io_write(0, sp_m[7:0]);
        io_write(1, sp_m[15:8]);
        chk(!irq_block, "R8 high write ends window", {31'h0, irq_block}, 32'h0);

        // R9 floor flag around 0x2000
        io_write(1, 8'h20);
        io_write(0, 8'h02);
        chk(!sp_low, "R9 0x2002 above floor", {31'h0, sp_low}, 32'h0);
        run_op(0, 8'h11, 24'h0, 0);
        chk(!sp_low, "R9 0x2001 above floor", {31'h0, sp_low}, 32'h0);
        run_op(0, 8'h22, 24'h0, 0);
        chk(sp_low, "R9 0x2000 at floor", {31'h0, sp_low}, 32'h1);
        run_op(1, 8'h00, 24'h0, 0);
        chk(!sp_low, "R9 back above floor", {31'h0, sp_low}, 32'h0);
        io_write(1, 8'h3F);
        io_write(0, 8'hFF);

        // R10 request during a call is ignored
        sp0 = sp_m;
        @(negedge clk);
        req_call = 1; call_addr = 24'h00BEEF; wide_ra = 0;
        @(negedge clk);
        req_call = 0; req_push = 1; push_byte = 8'h99;
        @(negedge clk);
        req_push = 0;
        while (busy) @(negedge clk);
        ref_mem[10'(sp0)] = 8'hEF;
        ref_mem[10'(sp0 - 16'd1)] = 8'hBE;
        sp_m = sp0 - 16'd2;
        chk({sp_hi, sp_lo} == sp_m, "R10 push during call ignored", {16'h0, sp_hi, sp_lo}, {16'h0, sp_m});
        run_op(3, 8'h00, 24'h0, 0);

        // R10 push wins over pop
        sp0 = sp_m;
        @(negedge clk);
        req_push = 1; req_pop = 1; push_byte = 8'h5A;
        @(negedge clk);
        req_push = 0; req_pop = 0;
        while (busy) @(negedge clk);
        ref_mem[10'(sp0)] = 8'h5A;
        sp_m = sp0 - 16'd1;
        chk({sp_hi, sp_lo} == sp_m, "R10 push beats pop", {16'h0, sp_hi, sp_lo}, {16'h0, sp_m});
        run_op(1, 8'h00, 24'h0, 0);

        // Seeded random mix
        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = int'($urandom % 4);
            run_op(kind, 8'($urandom), 24'($urandom), 1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule